// File: doc/BRIEF.md
# Condition Flag and Status Word Register

This block keeps the five condition flags of an 8-bit arithmetic/logic unit. Each clock, the unit presents the byte it just produced, the carry out of bit 7 and the carry out of bit 3. From these the block derives sign, zero, nibble carry, carry and even parity. It writes the value of each flag whose enable bit is set, and every other flag keeps its stored value. With all enables low, an operation such as a register move leaves every flag unchanged. With all enables high, an arithmetic operation refreshes every flag.

The stored flags are offered one by one, and also packed into a fixed flag byte. A 16-bit status word, with the accumulator in the high byte and the flag byte in the low byte, is formed for stack pushes. A pop restores the five flags from a byte in one clock. Reset is asserted asynchronously and released through a synchroniser.

Top module: `alu_flag_reg`

## Requirements
- R1: While reset is held, and for the synchroniser's stages after it is released, all five flags are 0 and the flag byte reads 8'h02.
- R2: When enable bit 4 is set and no restore is requested, the sign flag takes bit 7 of `res` at the clock edge.
- R3: When enable bit 3 is set and no restore is requested, the zero flag becomes 1 exactly when `res` is 8'h00.
- R4: When enable bit 2 is set and no restore is requested, the nibble-carry flag takes `c3_in`.
- R5: When enable bit 0 is set and no restore is requested, the carry flag takes `c7_in`.
- R6: When enable bit 1 is set and no restore is requested, the parity flag becomes 1 when `res` holds an even number of 1 bits, and 0 when it holds an odd number.
- R7: A flag whose enable bit is 0 keeps its value. With `upd_en` = 0 and no restore, the flag byte does not change.
- R8: The flag byte places sign at bit 7, zero at bit 6, nibble carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5 and 3 read 0 and bit 1 reads 1.
- R9: `psw` equals `{acc_in, flag_byte}` in the same cycle.
- R10: When `restore_en` is 1, all five flags load from bits 7, 6, 4, 2 and 0 of `restore_byte` in one clock. This takes priority over `upd_en`, and bits 5, 3 and 1 of `restore_byte` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res | input | 8 | Result byte of the current operation |
| c7_in | input | 1 | Carry out of bit 7 |
| c3_in | input | 1 | Carry out of bit 3 |
| upd_en | input | 5 | Per-flag write enable: bit 4 sign, 3 zero, 2 nibble carry, 1 parity, 0 carry |
| restore_en | input | 1 | Load the flags from `restore_byte` |
| restore_byte | input | 8 | Popped flag byte |
| acc_in | input | 8 | Accumulator value for the status word |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Nibble-carry flag |
| flag_p | output | 1 | Parity flag |
| flag_cy | output | 1 | Carry flag |
| flag_byte | output | 8 | Packed flag byte |
| psw | output | 16 | Status word `{acc_in, flag_byte}` |

## Verification
The bench drives a result of zero, which must set both zero and parity. It drives 8'h80, which must set sign and clear parity, and results with odd parity, which a design with inverted parity would report as even. Partial enable masks catch a flag that is written without its enable or wired to the wrong enable bit. A restore of 8'hFF must read back 8'hD7, so stray bits leaking into the don't-care positions show up. A restore issued together with a full update exposes a design that gives the wrong path priority. A swapped field in the packing would break the per-cycle comparison of the flag byte and the status word against the model.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int RES_W   = 8;
  localparam int NFLAG   = 5;
  // index of each flag in the flag vector and in the enable mask
  localparam int IX_CY   = 0;
  localparam int IX_P    = 1;
  localparam int IX_AC   = 2;
  localparam int IX_Z    = 3;
  localparam int IX_S    = 4;
  // bit positions inside the packed flag byte
  localparam int BP_S    = 7;
  localparam int BP_Z    = 6;
  localparam int BP_AC   = 4;
  localparam int BP_P    = 2;
  localparam int BP_CY   = 0;
  localparam logic [7:0] FIXED_ONES = 8'h02;

  typedef logic [NFLAG-1:0] flag_vec_t;

  function automatic logic [7:0] pack_flags(input flag_vec_t f);
    logic [7:0] b;
    b         = FIXED_ONES;
    b[BP_S]   = f[IX_S];
    b[BP_Z]   = f[IX_Z];
    b[BP_AC]  = f[IX_AC];
    b[BP_P]   = f[IX_P];
    b[BP_CY]  = f[IX_CY];
    return b;
  endfunction
endpackage

// File: rtl/flag_rst_sync.sv
module flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/flag_eval.sv
module flag_eval
  import flag_pkg::*;
#(
  parameter int W = RES_W
) (
  input  logic [W-1:0] res,
  input  logic         c7_in,
  input  logic         c3_in,
  output flag_vec_t    cand
);
  localparam int MSB = W - 1;

  always_comb begin
    cand        = '0;
    cand[IX_S]  = res[MSB];
    cand[IX_Z]  = (res == '0);
    cand[IX_AC] = c3_in;
    cand[IX_P]  = ~(^res);
    cand[IX_CY] = c7_in;
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import flag_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cand,
  input  logic [N-1:0] wr_en,
  input  logic         load,
  input  logic [N-1:0] load_val,
  output logic [N-1:0] q
);
  logic [N-1:0] d;
  logic [N-1:0] en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      en[i] = load | wr_en[i];
      d[i]  = load ? load_val[i] : cand[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= 1'b0;
      else if (en[i]) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  res,
  input  logic        c7_in,
  input  logic        c3_in,
  input  logic [4:0]  upd_en,
  input  logic        restore_en,
  input  logic [7:0]  restore_byte,
  input  logic [7:0]  acc_in,
  output logic        flag_s,
  output logic        flag_z,
  output logic        flag_ac,
  output logic        flag_p,
  output logic        flag_cy,
  output logic [7:0]  flag_byte,
  output logic [15:0] psw
);
  logic      rst_q_n;
  flag_vec_t cand;
  flag_vec_t pop_vec;
  flag_vec_t fq;
  logic      unused_pop_bits;

  flag_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  flag_eval #(.W(RES_W)) u_eval (
    .res   (res),
    .c7_in (c7_in),
    .c3_in (c3_in),
    .cand  (cand)
  );

  always_comb begin
    pop_vec        = '0;
    pop_vec[IX_S]  = restore_byte[BP_S];
    pop_vec[IX_Z]  = restore_byte[BP_Z];
    pop_vec[IX_AC] = restore_byte[BP_AC];
    pop_vec[IX_P]  = restore_byte[BP_P];
    pop_vec[IX_CY] = restore_byte[BP_CY];
  end

  assign unused_pop_bits = ^{restore_byte[5], restore_byte[3], restore_byte[1]};

  flag_bank #(.N(NFLAG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cand     (cand),
    .wr_en    (upd_en),
    .load     (restore_en),
    .load_val (pop_vec),
    .q        (fq)
  );

  assign flag_s    = fq[IX_S];
  assign flag_z    = fq[IX_Z];
  assign flag_ac   = fq[IX_AC];
  assign flag_p    = fq[IX_P];
  assign flag_cy   = fq[IX_CY];
  assign flag_byte = pack_flags(fq);
  assign psw       = {acc_in, flag_byte};
endmodule

// File: rtl/alu_flag_reg_chk.sv
module alu_flag_reg_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic [7:0] res,
  input logic       c7_in,
  input logic       c3_in,
  input logic [4:0] upd_en,
  input logic       restore_en,
  input logic [7:0] restore_byte,
  input logic       flag_s,
  input logic       flag_z,
  input logic       flag_ac,
  input logic       flag_p,
  input logic       flag_cy,
  input logic [7:0] flag_byte
);
  // R2
  s_upd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en[4] && !restore_en) |=> (flag_s == $past(res[7])));
  // R3
  z_upd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en[3] && !restore_en) |=> (flag_z == ($past(res) == 8'h00)));
  // R4
  ac_upd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en[2] && !restore_en) |=> (flag_ac == $past(c3_in)));
  // R5
  cy_upd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en[0] && !restore_en) |=> (flag_cy == $past(c7_in)));
  // R6
  p_upd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en[1] && !restore_en) |=> (flag_p == ($countones($past(res)) % 2 == 0)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en == 5'd0 && !restore_en) |=> $stable(flag_byte));
  // R10
  restore_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    restore_en |=> (flag_byte == (($past(restore_byte) & 8'hD5) | 8'h02)));
endmodule

bind alu_flag_reg alu_flag_reg_chk chk_i (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .res          (res),
  .c7_in        (c7_in),
  .c3_in        (c3_in),
  .upd_en       (upd_en),
  .restore_en   (restore_en),
  .restore_byte (restore_byte),
  .flag_s       (flag_s),
  .flag_z       (flag_z),
  .flag_ac      (flag_ac),
  .flag_p       (flag_p),
  .flag_cy      (flag_cy),
  .flag_byte    (flag_byte)
);

// File: tb/alu_flag_reg_tb_top.sv
module alu_flag_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  res;
  logic        c7_in, c3_in;
  logic [4:0]  upd_en;
  logic        restore_en;
  logic [7:0]  restore_byte;
  logic [7:0]  acc_in;
  logic        flag_s, flag_z, flag_ac, flag_p, flag_cy;
  logic [7:0]  flag_byte;
  logic [15:0] psw;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // reference state: sign, zero, nibble carry, parity, carry
  bit m_s, m_z, m_ac, m_p, m_cy;

  always #2 clk = ~clk;

  alu_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .res(res), .c7_in(c7_in), .c3_in(c3_in),
    .upd_en(upd_en), .restore_en(restore_en), .restore_byte(restore_byte),
    .acc_in(acc_in), .flag_s(flag_s), .flag_z(flag_z), .flag_ac(flag_ac),
    .flag_p(flag_p), .flag_cy(flag_cy), .flag_byte(flag_byte), .psw(psw)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int model_byte();
    return m_s * 128 + m_z * 64 + m_ac * 16 + m_p * 4 + 2 + m_cy;
  endfunction

  task automatic compare_all();
    chk("R2 sign",   flag_s,  m_s);
    chk("R3 zero",   flag_z,  m_z);
    chk("R4 nibble", flag_ac, m_ac);
    chk("R6 parity", flag_p,  m_p);
    chk("R5 carry",  flag_cy, m_cy);
    chk("R8 byte",   flag_byte, model_byte());
    chk("R9 psw",    psw, acc_in * 256 + model_byte());
  endtask

  // apply one cycle of stimulus at a negedge, advance model, check at next negedge
  task automatic step(input logic [7:0] r, input bit c7, input bit c3,
                      input logic [4:0] en, input bit rs, input logic [7:0] rb,
                      input logic [7:0] acc);
    int ones;
    res = r; c7_in = c7; c3_in = c3; upd_en = en;
    restore_en = rs; restore_byte = rb; acc_in = acc;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    if (rs) begin
      m_s = rb[7]; m_z = rb[6]; m_ac = rb[4]; m_p = rb[2]; m_cy = rb[0];
    end else begin
      if (en[4]) m_s  = r[7];
      if (en[3]) m_z  = (r == 0);
      if (en[2]) m_ac = c3;
      if (en[1]) m_p  = (ones % 2 == 0);
      if (en[0]) m_cy = c7;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; res = 0; c7_in = 0; c3_in = 0; upd_en = 0;
    restore_en = 0; restore_byte = 0; acc_in = 8'h5A;
    {m_s, m_z, m_ac, m_p, m_cy} = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset byte", flag_byte, 8'h02);
    chk("R1 reset flags", {flag_s, flag_z, flag_ac, flag_p, flag_cy}, 0);
    // R1: release with full update requested; flags stay cleared through the synchroniser
    upd_en = 5'h1F; res = 8'h00;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync hold", flag_byte, 8'h02);
    upd_en = 5'h00;
    repeat (2) @(negedge clk);
    chk("R1 after release", flag_byte, 8'h02);

    // corner cases
    step(8'h00, 0, 0, 5'h1F, 0, 8'h00, 8'h11); // R3/R6 zero is even parity
    step(8'h80, 1, 0, 5'h1F, 0, 8'h00, 8'h22); // R2 sign, odd parity
    step(8'h07, 0, 1, 5'h1F, 0, 8'h00, 8'h33); // R4, odd parity
    step(8'h03, 1, 1, 5'h00, 0, 8'h00, 8'h44); // R7 nothing changes
    step(8'hFF, 0, 0, 5'h01, 0, 8'h00, 8'h55); // R7 only carry
    step(8'h00, 1, 1, 5'h0A, 0, 8'h00, 8'h66); // R7 zero+parity only
    step(8'h00, 0, 0, 5'h00, 1, 8'hFF, 8'h77); // R10 don't-care bits ignored
    chk("R10 restore FF", flag_byte, 8'hD7);
    step(8'hFF, 1, 1, 5'h1F, 1, 8'h2A, 8'h88); // R10 priority over update
    chk("R10 priority", flag_byte, 8'h02);
    step(8'h00, 0, 0, 5'h1F, 1, 8'h55, 8'h99); // R10 mixed pattern
    step(8'h01, 0, 0, 5'h00, 0, 8'h00, 8'hAA); // R7 hold after restore

    // random patterns
    for (int k = 0; k < 3000; k++) begin
      step($urandom, $urandom, $urandom, $urandom,
           ($urandom % 8) == 0, $urandom, $urandom);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule